// File: doc/BRIEF.md
# Envelope Sample FIFO with Fill-Level Interrupt

This block buffers the output of an echo-envelope detector so that a processor can collect samples in bursts instead of servicing every update. Each envelope update arrives as a one-cycle strobe with a 16-bit word. The word is stored only while the capture switch `load_en` is high. The processor takes the oldest stored word with a one-cycle read strobe, and a counter reports how many words are held.

Two sticky status bits track the buffer. The first is a fill-level hit, raised when the word count matches a programmable 4-bit setting. A setting of 0 turns this source off. The second is an overflow, raised when a word arrives while the buffer is full and no read frees a slot in the same cycle. Each status bit has its own enable that gates it onto an interrupt line. A flag-clear pulse resets both status bits, and a flush pulse empties the buffer.

Top module: `env_fifo_top`

## Requirements
- R1: After synchronous reset, `fill_cnt` is 0, `rd_data` is 0, and `lvl_stat`, `ovf_stat`, `irq_lvl` and `irq_ovf` are all 0.
- R2: A word is accepted only in a cycle where `env_valid` and `load_en` are both 1. `fill_cnt` rises by one on the next clock edge.
- R3: When the buffer holds 8 words, an arriving word with no read in the same cycle is dropped. The stored words and `fill_cnt` are unchanged, and `ovf_stat` is 1 from the next edge until it is cleared.
- R4: A read strobe on a non-empty buffer places the oldest word on `rd_data` after the next edge and lowers `fill_cnt` by one. Words leave in the order they were accepted.
- R5: A read strobe on an empty buffer has no effect. `rd_data` keeps its previous value and `fill_cnt` stays 0.
- R6: A read strobe and an arriving word in the same cycle on a full buffer are both accepted. `fill_cnt` stays 8 and `ovf_stat` is not set.
- R7: In a cycle where `lvl_set` is nonzero and equals `fill_cnt`, `lvl_stat` becomes 1 at the next edge and stays 1 until cleared. A `lvl_set` of 0 never sets it.
- R8: `irq_lvl` equals `lvl_stat` AND `lvl_ie`, and `irq_ovf` equals `ovf_stat` AND `ovf_ie`, with no added delay.
- R9: A `flag_clr` pulse clears both status bits at the next edge. If a set condition is present in the same cycle, the set wins.
- R10: A `flush` pulse makes `fill_cnt` 0 at the next edge. Any read or write in that cycle is ignored, and the status bits are left as they were.
- R11: `fill_cnt` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| env_valid | input | 1 | Envelope update strobe |
| env_data | input | 16 | Envelope word |
| load_en | input | 1 | Capture enable |
| rd_stb | input | 1 | Pop strobe |
| rd_data | output | 16 | Last popped word |
| flush | input | 1 | Empty the buffer |
| flag_clr | input | 1 | Clear both status bits |
| lvl_set | input | 4 | Fill-level setting, 0 disables |
| lvl_ie | input | 1 | Level interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| fill_cnt | output | 4 | Number of stored words |
| lvl_stat | output | 1 | Sticky level-hit status |
| ovf_stat | output | 1 | Sticky overflow status |
| irq_lvl | output | 1 | Gated level interrupt |
| irq_ovf | output | 1 | Gated overflow interrupt |

## Verification
`fill_cnt` and `rd_data` are due one edge after their strobe. The overflow status is also due one edge after the failed write. The level status follows the count, so it lags the write that produced the matching count by two edges. The interrupt lines follow the status bits in the same cycle. The bench drives inputs on the falling edge and advances its model by one cycle. It compares every output on the next falling edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/env_fifo_pkg.sv
package env_fifo_pkg;
    localparam int unsigned ENV_DATA_W = 16;
    localparam int unsigned ENV_DEPTH  = 8;

    typedef struct packed {
        logic lvl;
        logic ovf;
    } env_flag_t;

    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/env_fifo_store.sv
module env_fifo_store
    import env_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = ENV_DATA_W,
    parameter int unsigned DEPTH  = ENV_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              flush,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic              ovf_try
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, empty, rd_acc, wr_acc;

    assign full    = (fill_cnt == CNT_W'(DEPTH));
    assign empty   = (fill_cnt == '0);
    assign rd_acc  = rd_stb && !empty && !flush;
    assign wr_acc  = wr_req && !flush && (!full || rd_acc);
    assign ovf_try = wr_req && !flush && full && !rd_acc;

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
            rd_data  <= '0;
        end else if (flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (wr_acc) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
            if (rd_acc) begin
                rd_ptr  <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
                rd_data <= mem[rd_ptr];
            end
            case ({wr_acc, rd_acc})
                2'b10:   fill_cnt <= fill_cnt + 1'b1;
                2'b01:   fill_cnt <= fill_cnt - 1'b1;
                default: fill_cnt <= fill_cnt;
            endcase
        end
    end

    p_cnt_max_r11: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(DEPTH));
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && !rd_stb && !flush) |=> fill_cnt == CNT_W'(DEPTH));
    p_empty_rd_r5: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_stb && !wr_req && !flush) |=> ($stable(rd_data) && fill_cnt == '0));
    p_rdwr_full_r6: assert property (@(posedge clk) disable iff (rst)
        (full && rd_stb && wr_req && !flush) |=> fill_cnt == CNT_W'(DEPTH));
    p_flush_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> fill_cnt == '0);
endmodule

// File: rtl/env_fifo_flags.sv
module env_fifo_flags
    import env_fifo_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [CNT_W-1:0] lvl_set,
    input  logic             ovf_try,
    input  logic             flag_clr,
    input  logic             lvl_ie,
    input  logic             ovf_ie,
    output logic             lvl_stat,
    output logic             ovf_stat,
    output logic             irq_lvl,
    output logic             irq_ovf
);
    env_flag_t st, hit;

    assign hit.lvl = (lvl_set != '0) && (fill_cnt == lvl_set);
    assign hit.ovf = ovf_try;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= hit | (flag_clr ? env_flag_t'('0) : st);
    end

    assign lvl_stat = st.lvl;
    assign ovf_stat = st.ovf;
    assign irq_lvl  = st.lvl && lvl_ie;
    assign irq_ovf  = st.ovf && ovf_ie;

    p_lvl_hit_r7: assert property (@(posedge clk) disable iff (rst)
        ((lvl_set != '0) && (fill_cnt == lvl_set)) |=> lvl_stat);
    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_try |=> ovf_stat);
    p_clr_ovf_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !ovf_try) |=> !ovf_stat);
endmodule

// File: rtl/env_fifo_top.sv
module env_fifo_top
    import env_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = ENV_DATA_W,
    parameter int unsigned DEPTH  = ENV_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              env_valid,
    input  logic [DATA_W-1:0] env_data,
    input  logic              load_en,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    input  logic              flush,
    input  logic              flag_clr,
    input  logic [CNT_W-1:0]  lvl_set,
    input  logic              lvl_ie,
    input  logic              ovf_ie,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic              lvl_stat,
    output logic              ovf_stat,
    output logic              irq_lvl,
    output logic              irq_ovf
);
    logic wr_req, ovf_try;

    assign wr_req = env_valid && load_en;

    env_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(env_data),
        .rd_stb(rd_stb), .flush(flush), .rd_data(rd_data),
        .fill_cnt(fill_cnt), .ovf_try(ovf_try)
    );

    env_fifo_flags #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst(rst), .fill_cnt(fill_cnt), .lvl_set(lvl_set),
        .ovf_try(ovf_try), .flag_clr(flag_clr), .lvl_ie(lvl_ie), .ovf_ie(ovf_ie),
        .lvl_stat(lvl_stat), .ovf_stat(ovf_stat), .irq_lvl(irq_lvl), .irq_ovf(irq_ovf)
    );

    p_wr_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !rd_stb && !flush) |=> $stable(fill_cnt));
endmodule

// File: tb/env_fifo_top_test.sv
module env_fifo_top_test;
    logic        clk = 0;
    logic        rst;
    logic        env_valid, load_en, rd_stb, flush, flag_clr, lvl_ie, ovf_ie;
    logic [15:0] env_data;
    logic [3:0]  lvl_set;
    logic [15:0] rd_data;
    logic [3:0]  fill_cnt;
    logic        lvl_stat, ovf_stat, irq_lvl, irq_ovf;

    int n_chk = 0, n_bad = 0;

    // reference model
    logic [15:0] q [8];
    int          mc;
    logic [15:0] m_rd;
    logic        m_lvl, m_ovf;

    always #5 clk = ~clk;

    env_fifo_top uut (
        .clk(clk), .rst(rst), .env_valid(env_valid), .env_data(env_data),
        .load_en(load_en), .rd_stb(rd_stb), .rd_data(rd_data), .flush(flush),
        .flag_clr(flag_clr), .lvl_set(lvl_set), .lvl_ie(lvl_ie), .ovf_ie(ovf_ie),
        .fill_cnt(fill_cnt), .lvl_stat(lvl_stat), .ovf_stat(ovf_stat),
        .irq_lvl(irq_lvl), .irq_ovf(irq_ovf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic lvl_hit(input int cnt, input int lvl);
        return (lvl != 0) && (cnt == lvl);
    endfunction

    function automatic logic ovf_hit(input logic wr, input logic rd, input logic fl, input int cnt);
        return wr && !fl && (cnt == 8) && !rd;
    endfunction

    task automatic model_step();
        logic wr, racc, wacc, lh, oh;
        wr = env_valid && load_en;
        lh = lvl_hit(mc, int'(lvl_set));
        oh = ovf_hit(wr, rd_stb, flush, mc);
        m_lvl = lh | (m_lvl & !flag_clr);
        m_ovf = oh | (m_ovf & !flag_clr);
        if (flush) begin
            mc = 0;
        end else begin
            racc = rd_stb && (mc != 0);
            wacc = wr && ((mc != 8) || racc);
            if (racc) begin
                m_rd = q[0];
                for (int i = 0; i < 7; i++) q[i] = q[i+1];
                mc--;
            end
            if (wacc) begin
                q[mc] = env_data;
                mc++;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R11 fill_cnt"}, int'(fill_cnt), mc);
        chk({tag, " R4 rd_data"}, int'(rd_data), int'(m_rd));
        chk({tag, " R7 lvl_stat"}, int'(lvl_stat), int'(m_lvl));
        chk({tag, " R3 ovf_stat"}, int'(ovf_stat), int'(m_ovf));
        chk({tag, " R8 irq_lvl"}, int'(irq_lvl), int'(m_lvl && lvl_ie));
        chk({tag, " R8 irq_ovf"}, int'(irq_ovf), int'(m_ovf && ovf_ie));
    endtask

    // inputs already driven at a falling edge; advance one cycle and compare
    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic drive(input logic v, input logic ld, input logic [15:0] d,
                         input logic rd, input logic fl, input logic cl);
        env_valid = v; load_en = ld; env_data = d;
        rd_stb = rd; flush = fl; flag_clr = cl;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1;
        drive(0, 0, 16'h0, 0, 0, 0);
        lvl_set = 4'd0; lvl_ie = 1; ovf_ie = 1;
        mc = 0; m_rd = '0; m_lvl = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 fill_cnt", int'(fill_cnt), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 flags", int'({lvl_stat, ovf_stat, irq_lvl, irq_ovf}), 0);

        // R2: load_en low blocks capture
        drive(1, 0, 16'h1111, 0, 0, 0); cycle("R2 gated");
        chk("R2 no capture", int'(fill_cnt), 0);

        // R5: read on empty keeps rd_data
        drive(0, 0, 16'h0, 1, 0, 0); cycle("R5 empty read");

        // fill to 8 with level 8 (R7), then overflow (R3)
        lvl_set = 4'd8;
        for (int i = 0; i < 8; i++) begin
            drive(1, 1, 16'hA000 + 16'(i), 0, 0, 0); cycle("R2 fill");
        end
        drive(0, 0, 16'h0, 0, 0, 0); cycle("R7 level hit");
        chk("R7 lvl_stat at 8", int'(lvl_stat), 1);
        // R6: simultaneous read and write on full
        drive(1, 1, 16'hBEEF, 1, 0, 0); cycle("R6 rdwr full");
        chk("R6 no overflow", int'(ovf_stat), 0);
        chk("R6 popped oldest", int'(rd_data), 16'hA000);
        // R3: write into full
        drive(1, 1, 16'hDEAD, 0, 0, 0); cycle("R3 overflow");
        chk("R3 overflow set", int'(ovf_stat), 1);
        // R4: drain and check order
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, 16'h0, 1, 0, 0); cycle("R4 drain");
        end
        chk("R4 last word", int'(rd_data), 16'hBEEF);
        // R9 clear
        drive(0, 0, 16'h0, 0, 0, 1); cycle("R9 clear");
        chk("R9 cleared", int'({lvl_stat, ovf_stat}), 0);
        // R7 level 0 disabled
        lvl_set = 4'd0;
        drive(0, 0, 16'h0, 0, 0, 0); cycle("R7 level zero");
        chk("R7 level zero", int'(lvl_stat), 0);
        // R10 flush
        drive(1, 1, 16'h0042, 0, 0, 0); cycle("R10 prep");
        drive(1, 1, 16'h0043, 1, 1, 0); cycle("R10 flush");
        chk("R10 flushed", int'(fill_cnt), 0);

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 31) == 0) lvl_set = 4'($urandom_range(0, 8));
            lvl_ie = ($urandom_range(0, 3) != 0);
            ovf_ie = ($urandom_range(0, 3) != 0);
            drive($urandom_range(0, 99) < 55, $urandom_range(0, 99) < 85,
                  16'($urandom), $urandom_range(0, 99) < 40,
                  $urandom_range(0, 99) < 3, $urandom_range(0, 99) < 6);
            cycle("R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule